// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a pair of switch commands for one half-bridge leg, one for the upper switch and one for the lower, into timed digital gate-control selects. It never lets the two switches conduct together. A switch turns off on the clock edge that samples the command, and a switch turns on only after a programmable guard interval in which both switches are off. After every gate transition, on or off, that gate runs a timed high-current phase and then drops to a low holding current. The block supplies the strength code for each phase. While a gate is in its turn-on high-current phase, the block also asks for a strong pulldown on the opposite gate so that coupling cannot turn that gate on.

All durations are counted in clock cycles of period `CLK_NS` (20 ns by default) and rounded up to whole cycles. With `FIXED_CFG` set, the guard and high-current codes are ignored and fixed values are used. The outputs are digital selects for an analog driver stage, which is not part of this block.

Top module: `hbs_gate_seq`

## Requirements
- R1: After reset, and while both commands are low, every output is 0.
- R2: The guard code selects 40, 120, 200 or 400 ns for codes 0 to 3, which is 2, 6, 10 or 20 cycles at 20 ns. A gate turns on exactly that many cycles after the clock edge that samples its new command.
- R3: A gate turns off on the first clock edge that samples its command low. Turn-off is never delayed by the guard interval.
- R4: The peak code selects 500, 1000, 2000 or 4000 ns for codes 0 to 3, which is 25, 50, 100 or 200 cycles. After every on or off transition of a gate, that gate's peak flag is high for exactly that many cycles, starting with the transition cycle.
- R5: During a turn-on peak the gate's 3-bit strength output equals the source code, and during a turn-off peak it equals the sink code. Both codes are captured at the transition edge. Outside a peak the strength output is 000, the holding level of 15 mA source or 30 mA sink.
- R6: While one gate is on and in its peak phase, the strong-pulldown output of the opposite gate is 1. At all other times it is 0.
- R7: When both commands are high together, both gates are off from the next edge on.
- R8: A command change that arrives while the guard interval is still running restarts the guard count for the new target. No gate turns on before the restarted count expires.
- R9: While the enable input is low, both gates are off and both peak phases are cleared from the next edge on. After enable returns, a full guard interval passes before any gate turns on.
- R10: With `FIXED_CFG`=1, the guard interval is always 120 ns (6 cycles) and the peak phase is always 4000 ns (200 cycles), whatever the codes.
- R11: The two gate-on outputs are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low forces both gates off and clears the phases |
| hi_cmd_i | input | 1 | Upper switch command |
| lo_cmd_i | input | 1 | Lower switch command |
| dt_code_i | input | 2 | Guard-interval code |
| pk_code_i | input | 2 | High-current phase duration code |
| src_code_i | input | 3 | Source strength code for turn-on peaks |
| snk_code_i | input | 3 | Sink strength code for turn-off peaks |
| hs_on_o | output | 1 | Upper gate on |
| ls_on_o | output | 1 | Lower gate on |
| hs_peak_o | output | 1 | Upper gate in high-current phase |
| ls_peak_o | output | 1 | Lower gate in high-current phase |
| hs_str_o | output | 3 | Upper gate strength select |
| ls_str_o | output | 3 | Lower gate strength select |
| hs_pd_o | output | 1 | Strong pulldown request for upper gate |
| ls_pd_o | output | 1 | Strong pulldown request for lower gate |

## Verification
A wrong guard counter shows up as a gate-on edge one or more cycles away from the expected cycle. The bench checks the cycle just before the edge and the edge cycle itself, so an off-by-one error is caught on its first occurrence. A wrong peak counter or a wrong latched strength code shows up at the first peak of that gate: the peak flag, strength and pulldown outputs are checked at both the last peak cycle and the first hold cycle. A target register that misses a restart or an enable drop lets a gate turn on in a cycle where the bench expects it off, and this shows up within one guard interval.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HI   = 2'd1,
    TGT_LO   = 2'd2
  } tgt_e;

  // guard interval in ns for a 2-bit code
  function automatic int unsigned dead_ns(input logic [1:0] code);
    case (code)
      2'd0:    return 40;
      2'd1:    return 120;
      2'd2:    return 200;
      default: return 400;
    endcase
  endfunction

  // high-current phase in ns: doubles with each code step from 500 ns
  function automatic int unsigned peak_ns(input logic [1:0] code);
    return 500 << code;
  endfunction

  // round a duration up to whole clock cycles
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // command pair to target; conflicting commands mean no switch
  function automatic tgt_e decode_cmd(input logic hi, input logic lo);
    if (hi && !lo) return TGT_HI;
    if (lo && !hi) return TGT_LO;
    return TGT_NONE;
  endfunction

endpackage

// File: rtl/hbs_dead_timer.sv
module hbs_dead_timer
  import hbs_pkg::*;
#(
  parameter int unsigned CLK_NS    = 20,
  parameter bit          FIXED_CFG = 1'b0,
  parameter int unsigned CW        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       hi_i,
  input  logic       lo_i,
  input  logic [1:0] dt_code_i,
  output logic [1:0] on_nxt_o,
  output logic       restart_o
);

  tgt_e          tgt_in, tgt_q, tgt_n;
  logic [CW-1:0] cnt_q, cnt_n, dead_load;

  generate
    if (FIXED_CFG) begin : g_fixed_dt
      assign dead_load = CW'(ns_to_cyc(120, CLK_NS));
    end else begin : g_prog_dt
      always_comb dead_load = CW'(ns_to_cyc(dead_ns(dt_code_i), CLK_NS));
    end
  endgenerate

  assign tgt_in = decode_cmd(hi_i, lo_i);

  always_comb begin
    tgt_n     = tgt_q;
    cnt_n     = cnt_q;
    restart_o = 1'b0;
    if (!en_i) begin
      tgt_n = TGT_NONE;
      cnt_n = dead_load;
    end else if (tgt_in != tgt_q) begin
      tgt_n     = tgt_in;
      cnt_n     = dead_load;
      restart_o = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  assign on_nxt_o[0] = en_i && (tgt_n == TGT_HI) && (cnt_n == '0);
  assign on_nxt_o[1] = en_i && (tgt_n == TGT_LO) && (cnt_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_NONE;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/hbs_phase.sv
module hbs_phase
#(
  parameter int unsigned CLK_NS    = 20,
  parameter bit          FIXED_CFG = 1'b0,
  parameter int unsigned CW        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       on_nxt_i,
  input  logic [1:0] pk_code_i,
  input  logic [2:0] src_code_i,
  input  logic [2:0] snk_code_i,
  output logic       on_o,
  output logic       peak_o,
  output logic [2:0] str_o
);
  import hbs_pkg::*;

  logic          on_q;
  logic [CW-1:0] pk_cnt_q, pk_load;
  logic [2:0]    str_q;
  logic          flip;

  generate
    if (FIXED_CFG) begin : g_fixed_pk
      assign pk_load = CW'(ns_to_cyc(4000, CLK_NS));
    end else begin : g_prog_pk
      always_comb pk_load = CW'(ns_to_cyc(peak_ns(pk_code_i), CLK_NS));
    end
  endgenerate

  assign flip = en_i && (on_nxt_i != on_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      pk_cnt_q <= '0;
      str_q    <= 3'd0;
    end else if (!en_i) begin
      on_q     <= 1'b0;
      pk_cnt_q <= '0;
      str_q    <= 3'd0;
    end else if (flip) begin
      on_q     <= on_nxt_i;
      pk_cnt_q <= pk_load;
      str_q    <= on_nxt_i ? src_code_i : snk_code_i;
    end else if (pk_cnt_q != '0) begin
      pk_cnt_q <= pk_cnt_q - CW'(1);
    end
  end

  assign on_o   = on_q;
  assign peak_o = (pk_cnt_q != '0);
  assign str_o  = peak_o ? str_q : 3'd0;

endmodule

// File: rtl/hbs_gate_seq.sv
module hbs_gate_seq
  import hbs_pkg::*;
#(
  parameter int unsigned CLK_NS    = 20,
  parameter bit          FIXED_CFG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       hi_cmd_i,
  input  logic       lo_cmd_i,
  input  logic [1:0] dt_code_i,
  input  logic [1:0] pk_code_i,
  input  logic [2:0] src_code_i,
  input  logic [2:0] snk_code_i,
  output logic       hs_on_o,
  output logic       ls_on_o,
  output logic       hs_peak_o,
  output logic       ls_peak_o,
  output logic [2:0] hs_str_o,
  output logic [2:0] ls_str_o,
  output logic       hs_pd_o,
  output logic       ls_pd_o
);

  localparam int unsigned MAX_CYC = ns_to_cyc(4000, CLK_NS);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam int unsigned NGATE   = 2;

  logic [NGATE-1:0] on_nxt, on, peak;
  logic [2:0]       str [NGATE];
  logic             dead_restart;

  hbs_dead_timer #(.CLK_NS(CLK_NS), .FIXED_CFG(FIXED_CFG), .CW(CW)) u_dead (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .hi_i      (hi_cmd_i),
    .lo_i      (lo_cmd_i),
    .dt_code_i (dt_code_i),
    .on_nxt_o  (on_nxt),
    .restart_o (dead_restart)
  );

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    hbs_phase #(.CLK_NS(CLK_NS), .FIXED_CFG(FIXED_CFG), .CW(CW)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .on_nxt_i   (on_nxt[g]),
      .pk_code_i  (pk_code_i),
      .src_code_i (src_code_i),
      .snk_code_i (snk_code_i),
      .on_o       (on[g]),
      .peak_o     (peak[g]),
      .str_o      (str[g])
    );
  end

  assign hs_on_o   = on[0];
  assign ls_on_o   = on[1];
  assign hs_peak_o = peak[0];
  assign ls_peak_o = peak[1];
  assign hs_str_o  = str[0];
  assign ls_str_o  = str[1];
  // turn-on peak of one gate asks for a strong hold-off on the other
  assign hs_pd_o   = peak[1] & on[1];
  assign ls_pd_o   = peak[0] & on[0];

endmodule

// File: rtl/hbs_gate_seq_chk.sv
module hbs_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic hi_cmd_i,
  input logic lo_cmd_i,
  input logic hs_on_o,
  input logic ls_on_o,
  input logic hs_peak_o,
  input logic ls_peak_o,
  input logic hs_pd_o,
  input logic ls_pd_o,
  input logic dead_restart
);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on_o && ls_on_o));

  // R2
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_o) |-> $past(!ls_on_o));

  // R2
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on_o) |-> $past(!hs_on_o));

  // R3
  hs_fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !hi_cmd_i) |=> !hs_on_o);

  // R3
  ls_fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !lo_cmd_i) |=> !ls_on_o);

  // R7
  both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cmd_i && lo_cmd_i) |=> !(hs_on_o || ls_on_o));

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(hs_on_o || ls_on_o || hs_peak_o || ls_peak_o));

  // R4
  peak_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_on_o) || $fell(hs_on_o)) |-> hs_peak_o);

  // R6
  pd_own_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_pd_o && hs_on_o) && !(ls_pd_o && ls_on_o));

  // R6
  pd_with_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on_o) |-> hs_pd_o);

  // R8
  restart_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_restart |=> !(hs_on_o || ls_on_o));

endmodule

bind hbs_gate_seq hbs_gate_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .hi_cmd_i     (hi_cmd_i),
  .lo_cmd_i     (lo_cmd_i),
  .hs_on_o      (hs_on_o),
  .ls_on_o      (ls_on_o),
  .hs_peak_o    (hs_peak_o),
  .ls_peak_o    (ls_peak_o),
  .hs_pd_o      (hs_pd_o),
  .ls_pd_o      (ls_pd_o),
  .dead_restart (dead_restart)
);

// File: tb/hbs_gate_seq_tb_top.sv
module hbs_gate_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b0, hi = 1'b0, lo = 1'b0;
  logic [1:0] dt = 2'd0, pk = 2'd0;
  logic [2:0] src = 3'd0, snk = 3'd0;

  logic       h0, l0, hp0, lp0, hd0, ld0, h1, l1, hp1, lp1, hd1, ld1;
  logic [2:0] hs0, ls0, hs1, ls1;

  hbs_gate_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .hi_cmd_i(hi), .lo_cmd_i(lo),
    .dt_code_i(dt), .pk_code_i(pk), .src_code_i(src), .snk_code_i(snk),
    .hs_on_o(h0), .ls_on_o(l0), .hs_peak_o(hp0), .ls_peak_o(lp0),
    .hs_str_o(hs0), .ls_str_o(ls0), .hs_pd_o(hd0), .ls_pd_o(ld0));

  hbs_gate_seq #(.FIXED_CFG(1'b1)) dut_fix_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .hi_cmd_i(hi), .lo_cmd_i(lo),
    .dt_code_i(dt), .pk_code_i(pk), .src_code_i(src), .snk_code_i(snk),
    .hs_on_o(h1), .ls_on_o(l1), .hs_peak_o(hp1), .ls_peak_o(lp1),
    .hs_str_o(hs1), .ls_str_o(ls1), .hs_pd_o(hd1), .ls_pd_o(ld1));

  wire [11:0] obs0 = {h0, l0, hp0, lp0, hs0, ls0, hd0, ld0};
  wire [11:0] obs1 = {h1, l1, hp1, lp1, hs1, ls1, hd1, ld1};

  typedef struct {
    int         cyc;
    int         sel;
    logic [11:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected durations restated from the requirements at a 20 ns clock
  function automatic int dcyc(input int code);
    int ns_tab[4] = '{40, 120, 200, 400};
    return (ns_tab[code] + 19) / 20;
  endfunction
  function automatic int pcyc(input int code);
    return 25 * (1 << code);
  endfunction

  function automatic logic [11:0] vec(input bit hon, input bit lon,
                                      input bit hpk, input bit lpk,
                                      input logic [2:0] hstr, input logic [2:0] lstr,
                                      input bit hpd, input bit lpd);
    return {hon, lon, hpk, lpk, hstr, lstr, hpd, lpd};
  endfunction

  task automatic push(input int c, input int s, input logic [11:0] e, input string t);
    item_t it;
    it.cyc = c; it.sel = s; it.exp = e; it.tag = t;
    sbq.push_back(it);
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compare scoreboard items in the cycle they are due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      item_t it;
      logic [11:0] o;
      it = sbq.pop_front();
      o = (it.sel == 1) ? obs1 : obs0;
      n_run++;
      if (it.cyc != cyc || o !== it.exp) begin
        n_fail++;
        $display("FAIL %s cyc %0d dut %0d: actual %b expected %b",
                 it.tag, it.cyc, it.sel, o, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int c0, c1, c2, c3, d, p;
    push(2, 0, 12'd0, "R1");
    push(5, 0, 12'd0, "R1");
    push(5, 1, 12'd0, "R1");
    at(3);
    rst_n = 1'b1; en = 1'b1;

    // upper turn-on, shortest codes; fixed instance uses its own timing
    c0 = 10; d = dcyc(0); p = pcyc(0);
    push(c0 + d,         0, 12'd0, "R2");
    push(c0 + 1 + d,     0, vec(1,0,1,0,3'd5,3'd0,0,1), "R2 R5 R6");
    push(c0 + 6,         1, 12'd0, "R10");
    push(c0 + 7,         1, vec(1,0,1,0,3'd5,3'd0,0,1), "R10");
    push(c0 + d + p,     0, vec(1,0,1,0,3'd5,3'd0,0,1), "R4");
    push(c0 + d + p + 1, 0, vec(1,0,0,0,3'd0,3'd0,0,0), "R4 R5");
    push(c0 + 206,       1, vec(1,0,1,0,3'd5,3'd0,0,1), "R10");
    push(c0 + 207,       1, vec(1,0,0,0,3'd0,3'd0,0,0), "R10");
    at(c0);
    dt = 2'd0; pk = 2'd0; src = 3'd5; snk = 3'd3; hi = 1'b1;

    // hand over to the lower switch with the longest guard interval
    c1 = c0 + 220; d = dcyc(3); p = pcyc(1);
    push(c1 + 1,         0, vec(0,0,1,0,3'd6,3'd0,0,0), "R3");
    push(c1 + d,         0, vec(0,0,1,0,3'd6,3'd0,0,0), "R2");
    push(c1 + 1 + d,     0, vec(0,1,1,1,3'd6,3'd2,1,0), "R11");
    push(c1 + p,         0, vec(0,1,1,1,3'd6,3'd2,1,0), "R4");
    push(c1 + p + 1,     0, vec(0,1,0,1,3'd0,3'd2,1,0), "R5");
    push(c1 + d + p,     0, vec(0,1,0,1,3'd0,3'd2,1,0), "R6");
    push(c1 + d + p + 1, 0, vec(0,1,0,0,3'd0,3'd0,0,0), "R6");
    at(c1);
    dt = 2'd3; pk = 2'd1; src = 3'd2; snk = 3'd6; hi = 1'b0; lo = 1'b1;

    // conflicting commands
    c2 = c1 + 80; p = pcyc(0);
    push(c2 + 1,     0, vec(0,0,0,1,3'd0,3'd4,0,0), "R7");
    push(c2 + p,     0, vec(0,0,0,1,3'd0,3'd4,0,0), "R7");
    push(c2 + p + 1, 0, 12'd0, "R7");
    push(c2 + 40,    0, 12'd0, "R7");
    at(c2);
    pk = 2'd0; snk = 3'd4; hi = 1'b1;

    // change of target inside the guard interval, then enable drop
    c3 = c2 + 50; d = dcyc(2);
    push(c3 + 1 + d, 0, 12'd0, "R8");
    push(c3 + 5 + d, 0, 12'd0, "R8");
    push(c3 + 6 + d, 0, vec(0,1,0,1,3'd0,3'd7,1,0), "R8");
    push(c3 + 21,    0, 12'd0, "R9");
    push(c3 + 24,    0, 12'd0, "R9");
    push(c3 + 25 + d, 0, 12'd0, "R9");
    push(c3 + 26 + d, 0, vec(0,1,0,1,3'd0,3'd7,1,0), "R9");
    at(c3);
    dt = 2'd2; pk = 2'd2; src = 3'd7; hi = 1'b1; lo = 1'b0;
    at(c3 + 5);
    hi = 1'b0; lo = 1'b1;
    at(c3 + 20);
    en = 1'b0;
    at(c3 + 25);
    en = 1'b1;

    at(c3 + 60);
    if (sbq.size() != 0) begin
      n_fail++;
      n_run++;
      $display("FAIL R1 scoreboard: actual %0d pending expected 0", sbq.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule